// File: doc/BRIEF.md
# Flash Embedded-Operation Status Generator

This block produces the status byte that a parallel NOR flash places on its data bus while an embedded program or erase runs. The surrounding flash controller tells it which operation is under way and which sectors are marked for erasure. The block tracks two read-driven toggle bits, a pulse counter with a sticky timeout flag, and the window that follows a sector-erase command. On each bus read it returns either this status byte or the array data passed in from outside.

The two toggle bits work as a pair. The first one tells whether an embedded operation is actively running. The second one tells whether the sector being read is marked for erasure. A host that polls both bits can therefore tell active erase from erase suspend, and a selected sector from an unselected one. Once the timeout flag is set, it stays set until a reset command clears it. The reset command also reports which read mode the device returns to.

Top module: `flash_status_gen`

## Requirements
- R1: Operation state `op_i` is coded as 0 idle, 1 program, 2 erase, 3 erase suspended, 4 program during erase suspend. Codes 5 to 7 behave as idle. The run toggle (status bit 6) inverts once for each read cycle taken while the state is 1, 2 or 4. It keeps its value on reads in states 0 and 3, and in every cycle without a read.
- R2: The sector toggle (status bit 2) inverts once for each read cycle taken in state 2 or 3 whose sector index (the top `$clog2(SECTORS)` bits of `addr_i`) has its bit set in `sect_sel_i`. It keeps its value on every other cycle.
- R3: A read cycle is any cycle in which `oe_rd_i` or `ce_rd_i` is high. Either strobe alone advances the toggles. Both strobes high in the same cycle count as one read.
- R4: While no fault is pending, the pulse counter advances once per clock in states 1, 2 and 4. It holds in state 3 and clears in idle. The fault flag (status bit 5) becomes 1 after `PULSE_LIMIT` counted clocks.
- R5: Once set, the fault flag stays 1 until a reset command arrives. While it is set, `data_o` returns the status byte in every state, including idle.
- R6: A reset command (`reset_cmd_i` high for one cycle) while the fault flag is set clears the flag and the counter at the next clock. In the same cycle it pulses `exit_susp_o` if the state is 4, and `exit_array_o` otherwise.
- R7: A reset command while no fault is pending has no effect: no exit pulse, and the counter and status bits continue unchanged.
- R8: `erase_cmd_i` opens an erase window lasting `ERASE_WIN` clocks. A new command during the window restarts it. In state 2, status bit 3 reads 0 while the window is open and 1 once it has closed. In every other state bit 3 reads 0.
- R9: `data_o` shows the status byte when a fault is pending, when the state is 1, 2 or 4, or when the state is 3 and the addressed sector is selected. Otherwise it passes `array_i` through.
- R10: Status bits 7, 4, 1 and 0 always read 0.
- R11: After reset, both toggles, the fault flag, the counter and the erase window are clear. In state 2 with no read, the status byte therefore reads 0x08.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Operation state code |
| oe_rd_i | input | 1 | Read cycle qualified by output enable |
| ce_rd_i | input | 1 | Read cycle qualified by chip enable |
| addr_i | input | ADDR_W | Read address |
| sect_sel_i | input | SECTORS | Per-sector erase-select mask |
| array_i | input | 8 | Array data for non-status reads |
| reset_cmd_i | input | 1 | Reset command pulse |
| erase_cmd_i | input | 1 | Sector-erase command pulse |
| data_o | output | 8 | Read data: status byte or array data |
| exit_array_o | output | 1 | Reset cleared a fault; return to array read |
| exit_susp_o | output | 1 | Reset cleared a fault; return to erase-suspend read |

## Verification
The assertions take for granted that `op_i` is steady across each clock edge. They also assume that command pulses and read strobes are sampled exactly once per cycle, so that one high cycle is one event. The stimulus drives every input once per cycle, half a period away from the sampling edge. It holds each operation state for several cycles, so that timeouts and suspend transitions occur. Random cycles draw only the five legal state codes, which keeps them inside these assumptions.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

    typedef enum logic [2:0] {
        OP_IDLE      = 3'd0,
        OP_PROG      = 3'd1,
        OP_ERASE     = 3'd2,
        OP_SUSP      = 3'd3,
        OP_SUSP_PROG = 3'd4
    } op_state_e;

    typedef struct packed {
        logic       zero7;
        logic       run_tog;
        logic       fault;
        logic       zero4;
        logic       win_done;
        logic       sect_tog;
        logic [1:0] zero10;
    } status_t;

    function automatic logic op_running(input logic [2:0] op);
        return (op == OP_PROG) || (op == OP_ERASE) || (op == OP_SUSP_PROG);
    endfunction

    function automatic logic op_erase_scope(input logic [2:0] op);
        return (op == OP_ERASE) || (op == OP_SUSP);
    endfunction

endpackage

// File: rtl/fsg_toggle_pair.sv
module fsg_toggle_pair (
    input  logic clk,
    input  logic rst,
    input  logic flip_run_i,
    input  logic flip_sect_i,
    output logic run_tog_o,
    output logic sect_tog_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_tog_o  <= 1'b0;
            sect_tog_o <= 1'b0;
        end else begin
            if (flip_run_i)  run_tog_o  <= ~run_tog_o;
            if (flip_sect_i) sect_tog_o <= ~sect_tog_o;
        end
    end

    assert_run_flip_R1: assert property (@(posedge clk) disable iff (rst)
        flip_run_i |=> run_tog_o != $past(run_tog_o));
    assert_run_hold_R1: assert property (@(posedge clk) disable iff (rst)
        !flip_run_i |=> $stable(run_tog_o));
    assert_sect_flip_R2: assert property (@(posedge clk) disable iff (rst)
        flip_sect_i |=> sect_tog_o != $past(sect_tog_o));
    assert_sect_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !flip_sect_i |=> $stable(sect_tog_o));

endmodule

// File: rtl/fsg_pulse_timer.sv
module fsg_pulse_timer #(
    parameter int PULSE_LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic running_i,
    input  logic idle_i,
    input  logic susp_prog_i,
    input  logic reset_cmd_i,
    output logic fault_o,
    output logic exit_array_o,
    output logic exit_susp_o
);

    localparam int CNT_W = $clog2(PULSE_LIMIT + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PULSE_LIMIT - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             clear_fault;

    assign clear_fault  = reset_cmd_i && fault_o;
    assign exit_array_o = clear_fault && !susp_prog_i;
    assign exit_susp_o  = clear_fault && susp_prog_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            fault_o <= 1'b0;
        end else if (clear_fault) begin
            cnt_q   <= '0;
            fault_o <= 1'b0;
        end else if (!fault_o) begin
            if (idle_i) begin
                cnt_q <= '0;
            end else if (running_i) begin
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == LAST) fault_o <= 1'b1;
            end
        end
    end

    assert_fault_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        fault_o && !reset_cmd_i |=> fault_o);
    assert_fault_clear_R6: assert property (@(posedge clk) disable iff (rst)
        reset_cmd_i && fault_o |=> !fault_o);
    assert_exit_onehot_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({exit_array_o, exit_susp_o}));
    assert_no_fault_rise_idle_R4: assert property (@(posedge clk) disable iff (rst)
        !fault_o && !running_i |=> !fault_o);
    assert_no_exit_clean_R7: assert property (@(posedge clk) disable iff (rst)
        !fault_o |-> !exit_array_o && !exit_susp_o);

endmodule

// File: rtl/fsg_erase_window.sv
module fsg_erase_window #(
    parameter int ERASE_WIN = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    output logic open_o
);

    localparam int WC_W = $clog2(ERASE_WIN + 1);
    localparam logic [WC_W-1:0] LAST = WC_W'(ERASE_WIN - 1);

    logic [WC_W-1:0] wc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            open_o <= 1'b0;
            wc_q   <= '0;
        end else if (start_i) begin
            open_o <= 1'b1;
            wc_q   <= '0;
        end else if (open_o) begin
            wc_q <= wc_q + 1'b1;
            if (wc_q == LAST) open_o <= 1'b0;
        end
    end

    assert_window_opens_R8: assert property (@(posedge clk) disable iff (rst)
        start_i |=> open_o);
    assert_window_no_reopen_R8: assert property (@(posedge clk) disable iff (rst)
        !open_o && !start_i |=> !open_o);

endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
    import fsg_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int SECTORS     = 8,
    parameter int PULSE_LIMIT = 16,
    parameter int ERASE_WIN   = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [2:0]         op_i,
    input  logic               oe_rd_i,
    input  logic               ce_rd_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [SECTORS-1:0] sect_sel_i,
    input  logic [7:0]         array_i,
    input  logic               reset_cmd_i,
    input  logic               erase_cmd_i,
    output logic [7:0]         data_o,
    output logic               exit_array_o,
    output logic               exit_susp_o
);

    localparam int SECT_W = (SECTORS > 1) ? $clog2(SECTORS) : 1;

    logic [SECT_W-1:0] sect_idx;
    logic              sect_hit;
    logic              rd;
    logic              running;
    logic              run_tog, sect_tog, fault, win_open;
    logic              show_status;
    status_t           stat;

    generate
        if (SECTORS > 1) begin : g_multi
            assign sect_idx = addr_i[ADDR_W-1 -: SECT_W];
        end else begin : g_single
            assign sect_idx = 1'b0;
        end
    endgenerate

    assign sect_hit = sect_sel_i[sect_idx];
    assign rd       = oe_rd_i || ce_rd_i;
    assign running  = op_running(op_i);

    fsg_toggle_pair u_tog (
        .clk         (clk),
        .rst         (rst),
        .flip_run_i  (rd && running),
        .flip_sect_i (rd && op_erase_scope(op_i) && sect_hit),
        .run_tog_o   (run_tog),
        .sect_tog_o  (sect_tog)
    );

    fsg_pulse_timer #(.PULSE_LIMIT(PULSE_LIMIT)) u_timer (
        .clk          (clk),
        .rst          (rst),
        .running_i    (running),
        .idle_i       (!running && op_i != OP_SUSP),
        .susp_prog_i  (op_i == OP_SUSP_PROG),
        .reset_cmd_i  (reset_cmd_i),
        .fault_o      (fault),
        .exit_array_o (exit_array_o),
        .exit_susp_o  (exit_susp_o)
    );

    fsg_erase_window #(.ERASE_WIN(ERASE_WIN)) u_win (
        .clk     (clk),
        .rst     (rst),
        .start_i (erase_cmd_i),
        .open_o  (win_open)
    );

    always_comb begin
        stat          = '0;
        stat.run_tog  = run_tog;
        stat.fault    = fault;
        stat.win_done = (op_i == OP_ERASE) && !win_open;
        stat.sect_tog = sect_tog;
        show_status   = fault || running || (op_i == OP_SUSP && sect_hit);
        data_o        = show_status ? stat : array_i;
    end

    always_comb begin
        if (!rst && show_status)
            assert_zero_bits_R10: assert ((data_o & 8'h93) == 8'h00);
    end

endmodule

// File: tb/flash_status_gen_tb.sv
`timescale 1ns/1ps
module flash_status_gen_tb;

    localparam int ADDR_W = 12;
    localparam int SECTORS = 8;
    localparam int LIMIT = 16;
    localparam int WIN = 8;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [2:0]         op = 3'd0;
    logic               oe = 1'b0, ce = 1'b0, rcmd = 1'b0, ecmd = 1'b0;
    logic [ADDR_W-1:0]  addr = '0;
    logic [SECTORS-1:0] mask = '0;
    logic [7:0]         arr = 8'h00;
    logic [7:0]         data_o;
    logic               exit_array_o, exit_susp_o;

    int checks = 0, errors = 0;
    bit done = 0;

    bit m_a, m_b, m_fault, m_open;
    int m_cnt, m_wc;

    always #4 clk = ~clk;

    flash_status_gen #(.ADDR_W(ADDR_W), .SECTORS(SECTORS),
                       .PULSE_LIMIT(LIMIT), .ERASE_WIN(WIN)) u_dut (
        .clk(clk), .rst(rst), .op_i(op), .oe_rd_i(oe), .ce_rd_i(ce),
        .addr_i(addr), .sect_sel_i(mask), .array_i(arr),
        .reset_cmd_i(rcmd), .erase_cmd_i(ecmd), .data_o(data_o),
        .exit_array_o(exit_array_o), .exit_susp_o(exit_susp_o));

    function automatic bit running(input logic [2:0] o);
        return o == 3'd1 || o == 3'd2 || o == 3'd4;
    endfunction

    function automatic bit hit();
        return mask[addr[ADDR_W-1 -: 3]];
    endfunction

    function automatic logic [7:0] exp_data();
        bit show = m_fault || running(op) || (op == 3'd3 && hit());
        logic [7:0] s = {1'b0, m_a, m_fault, 1'b0,
                         (op == 3'd2) && !m_open, m_b, 2'b00};
        return show ? s : arr;
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input string tag);
        bit rd, clr;
        #1;
        check(tag, data_o, exp_data());
        clr = rcmd && m_fault;
        check({tag, " R6 exits"}, {6'd0, exit_susp_o, exit_array_o},
              {6'd0, clr && op == 3'd4, clr && op != 3'd4});
        rd = oe || ce;
        if (rd && running(op)) m_a = !m_a;
        if (rd && (op == 3'd2 || op == 3'd3) && hit()) m_b = !m_b;
        if (clr) begin
            m_fault = 0; m_cnt = 0;
        end else if (!m_fault) begin
            if (running(op)) begin
                if (m_cnt == LIMIT - 1) m_fault = 1;
                m_cnt++;
            end else if (op != 3'd3) m_cnt = 0;
        end
        if (ecmd) begin
            m_open = 1; m_wc = 0;
        end else if (m_open) begin
            if (m_wc == WIN - 1) m_open = 0;
            m_wc++;
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        oe = 0; ce = 0; rcmd = 0; ecmd = 0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        m_a = 0; m_b = 0; m_fault = 0; m_open = 0; m_cnt = 0; m_wc = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R11 reset state: erase state, no read shows 0x08
        op = 3'd2; arr = 8'hA5;
        #1 check("R11 reset status", data_o, 8'h08);
        step("R11");
        // R9 idle passes array data
        op = 3'd0; arr = 8'h5A;
        #1 check("R9 idle array", data_o, 8'h5A);
        step("R9");
        // R1/R3 toggle via oe, ce, both
        op = 3'd2; mask = 8'h01; addr = 12'h000;
        oe = 1; step("R1 oe read");
        oe = 0; ce = 1; step("R3 ce read");
        oe = 1; ce = 1; step("R3 both strobes");
        idle_inputs();
        #1 check("R3 one flip per cycle", data_o & 8'h44, 8'h44);
        step("R3");
        // R1 suspend: run toggle holds, sect toggle moves
        op = 3'd3; oe = 1; step("R1 suspend read");
        step("R2 suspend selected");
        // R2 unselected sector in suspend: array data, no flip
        addr = 12'hE00; arr = 8'h77; step("R9 suspend unselected");
        op = 3'd2; step("R2 unselected erase");
        idle_inputs();
        // R4/R5 timeout while programming
        op = 3'd0; step("R4 clear");
        op = 3'd1;
        for (int i = 0; i < LIMIT; i++) step("R4 count");
        #1 check("R4 fault set", data_o & 8'h20, 8'h20);
        op = 3'd0; step("R5 sticky in idle");
        // R7 reset without fault elsewhere handled; R6 reset with fault
        rcmd = 1; #1 check("R6 exit array", {7'd0, exit_array_o}, 8'd1);
        step("R6 clear");
        rcmd = 0;
        #1 check("R6 fault cleared", data_o, arr);
        // R6 suspend-program return
        op = 3'd4;
        for (int i = 0; i < LIMIT; i++) step("R4 susp prog");
        rcmd = 1; #1 check("R6 exit susp", {7'd0, exit_susp_o}, 8'd1);
        step("R6 susp");
        rcmd = 0;
        // R7 reset with no fault ignored
        op = 3'd1; step("R7 run");
        rcmd = 1; step("R7 ignored");
        rcmd = 0; step("R7 after");
        // R4 counter holds across suspend
        op = 3'd0; step("R4 clear2");
        op = 3'd2; for (int i = 0; i < LIMIT - 2; i++) step("R4 pre");
        op = 3'd3; for (int i = 0; i < 5; i++) step("R4 hold");
        op = 3'd2; step("R4 last-1"); step("R4 last");
        #1 check("R4 fault after resume", data_o & 8'h20, 8'h20);
        rcmd = 1; step("R6"); rcmd = 0;
        // R8 erase window and restart
        op = 3'd2; ecmd = 1; step("R8 start"); ecmd = 0;
        #1 check("R8 window open", data_o & 8'h08, 8'h00);
        for (int i = 0; i < 3; i++) step("R8 open");
        ecmd = 1; step("R8 restart"); ecmd = 0;
        for (int i = 0; i < WIN; i++) step("R8 run");
        #1 check("R8 window closed", data_o & 8'h08, 8'h08);
        op = 3'd0; step("R8");
        // Random phase
        for (int n = 0; n < 4000; n++) begin
            if ($urandom_range(0, 15) == 0) op = 3'($urandom_range(0, 4));
            oe = ($urandom_range(0, 2) == 0);
            ce = ($urandom_range(0, 3) == 0);
            addr = ADDR_W'($urandom);
            if ($urandom_range(0, 31) == 0) mask = SECTORS'($urandom);
            arr = 8'($urandom);
            rcmd = ($urandom_range(0, 40) == 0);
            ecmd = ($urandom_range(0, 30) == 0);
            step("R10 random");
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule